// File: doc/BRIEF.md
# MDIO Management Frame Engine

This block is a management-bus master that runs one clause 22 transaction at a time. The whole transaction lives in one packed 32-bit access word. Software first writes the target PHY address, register address, operation code, start code and write data with the go bit clear. It then writes the same word again with the go bit set. From then on the go bit reads back as a busy flag. The engine serialises the frame on MDC/MDIO. For a read it captures the 16 bits the PHY returns. When the last bit time ends it clears the go bit and, for a read, puts the captured value into the low half of the same word.

The MDC rate comes from a separate 6-bit divider input. A separate enable adds a 32-bit all-ones preamble. The frame controller is a state machine with six named states. S_IDLE waits for an accepted go request, then moves to S_PREAMBLE if the preamble is enabled and to S_HEADER if not. S_PREAMBLE leaves for S_HEADER after its last preamble bit. S_HEADER leaves for S_TURN after 14 bits. S_TURN leaves for S_DATA after 2 bits. S_DATA leaves for S_FINISH after 16 bits. S_FINISH returns to S_IDLE after one cycle. Every bit-advancing transition happens on an MDC falling edge. A separate MDC generator and an access-word holder sit beside the state machine.

Top module: `mdio_cmd_engine`

## Requirements
- R1: The access word has these fields: bit 31 go/busy, bits 29:25 register address, bits 24:20 PHY address, bits 19:18 operation code, bits 17:16 start code, bits 15:0 data. Bit 30 always reads 0.
- R2: A write to the word while bit 31 is clear stores all fields. If the written bit 31 is 1 and the operation code is 1 (write) or 2 (read), bit 31 reads 1 from the next cycle and a frame starts.
- R3: A go request with operation code 0 or 3 stores the fields with bit 31 clear, and MDC stays quiet.
- R4: Writes to the access word while bit 31 is set are ignored.
- R5: MDC idles low. Each MDC half period lasts mdc_div+1 clock cycles. MDIO changes only while MDC is low.
- R6: With preamble_en high the frame opens with 32 driven ones. With it low, no preamble bits are sent.
- R7: After any preamble the engine sends, MSB first: the start code (bits 17:16), the operation code (bits 19:18), the PHY address and then the register address.
- R8: For a write, the turnaround is driven as 1 then 0, followed by bits 15:0 MSB first, with the output enabled for every bit.
- R9: For a read, the output enable is low for the 2 turnaround and 16 data bit times. mdio_i is sampled on each MDC rising edge, MSB first, and the 16 bits replace bits 15:0 when the frame ends.
- R10: Bit 31 clears after the last data bit's falling edge. While bit 31 is clear, mdio_oe and mdc are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_wr_en | input | 1 | Write strobe for the access word |
| acc_wr_data | input | 32 | Value to write into the access word |
| acc_q | output | 32 | Current access word (busy flag, fields, read data) |
| mdc_div | input | DIV_W | MDC half period minus one, in clock cycles |
| preamble_en | input | 1 | Send a 32-bit preamble before each frame |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The bench uses the default build: a 6-bit divider and a 32-bit preamble. It sweeps divider values 0, 1 and 3, both preamble settings and both operations, across varied address and data patterns. A PHY model records every rising-edge bit and enable and answers reads. It compares these against frames built arithmetically, so every frame field, the turnaround and the MDC half-period are checked at short and longer rates. Dedicated cases cover go requests with unused operation codes and writes poked in mid-frame.

// File: rtl/mdio_eng_pkg.sv
`timescale 1ns/1ps
package mdio_eng_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PREAMBLE,
        S_HEADER,
        S_TURN,
        S_DATA,
        S_FINISH
    } mdio_state_e;

    localparam int HDR_BITS = 14;
    localparam int TA_BITS  = 2;
    localparam int DAT_BITS = 16;

    localparam int F_GO      = 31;
    localparam int F_REG_LSB = 25;
    localparam int F_PHY_LSB = 20;
    localparam int F_CMD_LSB = 18;
    localparam int F_SOF_LSB = 16;

    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;

    function automatic logic op_known(input logic [1:0] op);
        return (op == OP_WRITE) || (op == OP_READ);
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
`timescale 1ns/1ps
module mdio_mdc_gen #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_p,
    output logic             fall_p
);
    logic [DIV_W-1:0] hcnt;
    logic             wrap;

    assign wrap   = run && (hcnt == div);
    assign rise_p = wrap && !mdc;
    assign fall_p = wrap && mdc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hcnt <= '0;
            mdc  <= 1'b0;
        end else if (!run) begin
            hcnt <= '0;
            mdc  <= 1'b0;
        end else if (wrap) begin
            hcnt <= '0;
            mdc  <= ~mdc;
        end else begin
            hcnt <= hcnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_acc_reg.sv
`timescale 1ns/1ps
module mdio_acc_reg
    import mdio_eng_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic                fin,
    input  logic                fin_rd,
    input  logic [DAT_BITS-1:0] rd_data,
    output logic [WORD_W-1:0]   word_q,
    output logic                start
);
    logic accept;

    assign accept = wr_en && !word_q[F_GO];
    assign start  = accept && wr_data[F_GO] &&
                    op_known(wr_data[F_CMD_LSB +: 2]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (accept) begin
            word_q <= {start, 1'b0, wr_data[F_GO-2:0]};
        end else if (fin) begin
            word_q[F_GO] <= 1'b0;
            if (fin_rd) begin
                word_q[DAT_BITS-1:0] <= rd_data;
            end
        end
    end
endmodule

// File: rtl/mdio_frame_fsm.sv
`timescale 1ns/1ps
module mdio_frame_fsm
    import mdio_eng_pkg::*;
#(
    parameter int PRE_BITS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [HDR_BITS-1:0] hdr,
    input  logic [DAT_BITS-1:0] wdata,
    input  logic                is_rd,
    input  logic                pre_en,
    input  logic                rise_p,
    input  logic                fall_p,
    input  logic                mdio_i,
    output logic                run,
    output logic                mdio_o,
    output logic                mdio_oe,
    output logic                fin,
    output logic                fin_rd,
    output logic [DAT_BITS-1:0] rd_data
);
    localparam int CNT_W = $clog2(PRE_BITS + DAT_BITS + 1);

    mdio_state_e         state, nxt;
    logic [CNT_W-1:0]    bit_cnt;
    logic [HDR_BITS-1:0] hdr_sr;
    logic [DAT_BITS-1:0] dat_sr;
    logic [DAT_BITS-1:0] rd_sr;
    logic                rd_op;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:     if (start) nxt = pre_en ? S_PREAMBLE : S_HEADER;
            S_PREAMBLE: if (fall_p && bit_cnt == CNT_W'(PRE_BITS - 1)) nxt = S_HEADER;
            S_HEADER:   if (fall_p && bit_cnt == CNT_W'(HDR_BITS - 1)) nxt = S_TURN;
            S_TURN:     if (fall_p && bit_cnt == CNT_W'(TA_BITS - 1))  nxt = S_DATA;
            S_DATA:     if (fall_p && bit_cnt == CNT_W'(DAT_BITS - 1)) nxt = S_FINISH;
            S_FINISH:   nxt = S_IDLE;
            default:    nxt = S_IDLE;
        endcase
    end

    // datapath: bit counter, shifters, capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            hdr_sr  <= '0;
            dat_sr  <= '0;
            rd_sr   <= '0;
            rd_op   <= 1'b0;
        end else begin
            if (state != nxt)  bit_cnt <= '0;
            else if (fall_p)   bit_cnt <= bit_cnt + 1'b1;

            if (state == S_IDLE && start) begin
                hdr_sr <= hdr;
                dat_sr <= wdata;
                rd_op  <= is_rd;
            end else begin
                if (state == S_HEADER && fall_p) hdr_sr <= {hdr_sr[HDR_BITS-2:0], 1'b0};
                if (state == S_DATA && fall_p)   dat_sr <= {dat_sr[DAT_BITS-2:0], 1'b0};
            end

            if (state == S_DATA && rise_p && rd_op) begin
                rd_sr <= {rd_sr[DAT_BITS-2:0], mdio_i};
            end
        end
    end

    // outputs
    always_comb begin
        run     = 1'b0;
        mdio_o  = 1'b1;
        mdio_oe = 1'b0;
        fin     = 1'b0;
        unique case (state)
            S_IDLE: begin
            end
            S_PREAMBLE: begin
                run     = 1'b1;
                mdio_oe = 1'b1;
            end
            S_HEADER: begin
                run     = 1'b1;
                mdio_o  = hdr_sr[HDR_BITS-1];
                mdio_oe = 1'b1;
            end
            S_TURN: begin
                run     = 1'b1;
                mdio_o  = (bit_cnt == '0);
                mdio_oe = !rd_op;
            end
            S_DATA: begin
                run     = 1'b1;
                mdio_o  = dat_sr[DAT_BITS-1];
                mdio_oe = !rd_op;
            end
            S_FINISH: begin
                fin = 1'b1;
            end
            default: begin
            end
        endcase
    end

    assign fin_rd  = fin && rd_op;
    assign rd_data = rd_sr;
endmodule

// File: rtl/mdio_cmd_engine.sv
`timescale 1ns/1ps
module mdio_cmd_engine
    import mdio_eng_pkg::*;
#(
    parameter int DIV_W    = 6,
    parameter int PRE_BITS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_wr_en,
    input  logic [31:0]      acc_wr_data,
    output logic [31:0]      acc_q,
    input  logic [DIV_W-1:0] mdc_div,
    input  logic             preamble_en,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    input  logic             mdio_i
);
    logic                start, run, rise_p, fall_p, fin, fin_rd;
    logic [DAT_BITS-1:0] rd_data;
    logic [HDR_BITS-1:0] hdr;

    assign hdr = {acc_wr_data[F_SOF_LSB +: 2],
                  acc_wr_data[F_CMD_LSB +: 2],
                  acc_wr_data[F_PHY_LSB +: 5],
                  acc_wr_data[F_REG_LSB +: 5]};

    mdio_acc_reg #(.WORD_W(32)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (acc_wr_en),
        .wr_data (acc_wr_data),
        .fin     (fin),
        .fin_rd  (fin_rd),
        .rd_data (rd_data),
        .word_q  (acc_q),
        .start   (start)
    );

    mdio_mdc_gen #(.DIV_W(DIV_W)) u_mdc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .div    (mdc_div),
        .mdc    (mdc),
        .rise_p (rise_p),
        .fall_p (fall_p)
    );

    mdio_frame_fsm #(.PRE_BITS(PRE_BITS)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .hdr     (hdr),
        .wdata   (acc_wr_data[DAT_BITS-1:0]),
        .is_rd   (acc_wr_data[F_CMD_LSB +: 2] == OP_READ),
        .pre_en  (preamble_en),
        .rise_p  (rise_p),
        .fall_p  (fall_p),
        .mdio_i  (mdio_i),
        .run     (run),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .fin     (fin),
        .fin_rd  (fin_rd),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/mdio_cmd_engine_chk.sv
`timescale 1ns/1ps
module mdio_cmd_engine_chk
    import mdio_eng_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        acc_wr_en,
    input logic [31:0] acc_wr_data,
    input logic [31:0] acc_q,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe
);
    AST_GO_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_q[31] && acc_wr_en && acc_wr_data[31] && op_known(acc_wr_data[19:18])) |=> acc_q[31]); // R2

    AST_BAD_OP_NO_GO: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_q[31] && acc_wr_en && !op_known(acc_wr_data[19:18])) |=> !acc_q[31]); // R3

    AST_BUSY_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_q[31] && acc_wr_en) |=> (acc_q[29:16] == $past(acc_q[29:16]))); // R4

    AST_MDIO_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        mdc |-> $stable(mdio_o)); // R5

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_q[31] |-> (!mdc && !mdio_oe)); // R10
endmodule

bind mdio_cmd_engine mdio_cmd_engine_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_wr_en   (acc_wr_en),
    .acc_wr_data (acc_wr_data),
    .acc_q       (acc_q),
    .mdc         (mdc),
    .mdio_o      (mdio_o),
    .mdio_oe     (mdio_oe)
);

// File: tb/sim_mdio_cmd_engine.sv
`timescale 1ns/1ps
module sim_mdio_cmd_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_wr_en = 1'b0;
    logic [31:0] acc_wr_data = '0;
    logic [31:0] acc_q;
    logic [5:0]  mdc_div = '0;
    logic        preamble_en = 1'b0;
    logic        mdc, mdio_o, mdio_oe, mdio_i;

    int n_chk = 0;
    int n_fail = 0;
    bit ended = 1'b0;

    always #10 clk = ~clk;

    mdio_cmd_engine u0 (
        .clk(clk), .rst_n(rst_n), .acc_wr_en(acc_wr_en), .acc_wr_data(acc_wr_data),
        .acc_q(acc_q), .mdc_div(mdc_div), .preamble_en(preamble_en),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // PHY model
    int          rise_n = 0;
    int          base = 0;
    int          pre_len = 0;
    logic [15:0] phy_rd = '0;
    logic [63:0] cap_o = '0;
    logic [63:0] cap_oe = '0;
    time         t_r0 = 0;
    time         t_f0 = 0;

    initial forever begin
        @(posedge mdc);
        if (rise_n - base < 64) begin
            cap_o[rise_n - base]  = mdio_o;
            cap_oe[rise_n - base] = mdio_oe;
        end
        if (rise_n == base) t_r0 = $time;
        rise_n = rise_n + 1;
    end

    initial forever begin
        @(negedge mdc);
        if (rise_n == base + 1) t_f0 = $time;
    end

    assign mdio_i = (rise_n - base >= pre_len + 16 && rise_n - base < pre_len + 32)
                    ? phy_rd[pre_len + 31 - (rise_n - base)] : 1'b1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic run_txn(input logic [4:0] ra, input logic [4:0] pa, input logic [1:0] op,
                           input logic [15:0] wd, input logic [15:0] rv,
                           input logic [5:0] dv, input logic pe, input logic poke);
        logic        rd;
        logic [13:0] hdr;
        logic [63:0] eb, eo;
        logic [31:0] exp_q;
        int len, guard, pre_err, hdr_err, ta_err, dat_err, oe_err;
        rd = (op == 2'b10);
        @(negedge clk);
        mdc_div = dv;
        preamble_en = pe;
        phy_rd = rv;
        base = rise_n;
        pre_len = pe ? 32 : 0;
        acc_wr_data = {1'b0, 1'b1, ra, pa, op, 2'b01, wd};
        acc_wr_en = 1'b1;
        @(negedge clk);
        acc_wr_data[31] = 1'b1;
        @(negedge clk);
        acc_wr_en = 1'b0;
        chk("R2 go bit set", {31'd0, acc_q[31]}, 32'd1);
        chk("R1 fields and bit30", {1'b0, acc_q[30:0]}, {2'b00, ra, pa, op, 2'b01, wd});
        if (poke) begin
            repeat (3) @(negedge clk);
            acc_wr_en = 1'b1;
            acc_wr_data = ~{1'b0, 1'b1, ra, pa, op, 2'b01, wd};
            @(negedge clk);
            acc_wr_en = 1'b0;
            @(negedge clk);
            chk("R4 busy write ignored", acc_q, {1'b1, 1'b0, ra, pa, op, 2'b01, wd});
        end
        guard = 0;
        while (acc_q[31] && guard < 10000) begin
            @(negedge clk);
            guard++;
        end
        chk("R10 go bit cleared", {31'd0, acc_q[31]}, 32'd0);
        chk("R10 quiet when idle", {30'd0, mdc, mdio_oe}, 32'd0);
        len = pre_len + 32;
        chk("R6 bit count", 32'(rise_n - base), 32'(len));
        hdr = {2'b01, op, pa, ra};
        eb = '0;
        eo = '0;
        for (int i = 0; i < len; i++) begin
            if (i < pre_len) begin
                eb[i] = 1'b1; eo[i] = 1'b1;
            end else if (i < pre_len + 14) begin
                eb[i] = hdr[13 - (i - pre_len)]; eo[i] = 1'b1;
            end else if (i < pre_len + 16) begin
                eb[i] = (i == pre_len + 14); eo[i] = !rd;
            end else begin
                eb[i] = wd[15 - (i - pre_len - 16)]; eo[i] = !rd;
            end
        end
        pre_err = 0; hdr_err = 0; ta_err = 0; dat_err = 0; oe_err = 0;
        for (int i = 0; i < len; i++) begin
            if (cap_oe[i] !== eo[i]) oe_err++;
            if (eo[i] && cap_o[i] !== eb[i]) begin
                if (i < pre_len) pre_err++;
                else if (i < pre_len + 14) hdr_err++;
                else if (i < pre_len + 16) ta_err++;
                else dat_err++;
            end
        end
        chk("R6 preamble bits", 32'(pre_err), 32'd0);
        chk("R7 header bits", 32'(hdr_err), 32'd0);
        if (rd) begin
            chk("R9 output released", 32'(oe_err), 32'd0);
        end else begin
            chk("R8 drive enable", 32'(oe_err), 32'd0);
            chk("R8 turnaround bits", 32'(ta_err), 32'd0);
            chk("R8 data bits", 32'(dat_err), 32'd0);
        end
        exp_q = {2'b00, ra, pa, op, 2'b01, rd ? rv : wd};
        chk(rd ? "R9 read data" : "R1 word after write", acc_q, exp_q);
        chk("R5 half period", 32'(t_f0 - t_r0), 32'((32'(dv) + 1) * 20));
    endtask

    task automatic bad_op(input logic [1:0] op);
        @(negedge clk);
        base = rise_n;
        acc_wr_data = {1'b1, 1'b0, 5'd9, 5'd17, op, 2'b01, 16'h3C5A};
        acc_wr_en = 1'b1;
        @(negedge clk);
        acc_wr_en = 1'b0;
        repeat (40) @(negedge clk);
        chk("R3 fields kept without go", acc_q, {2'b00, 5'd9, 5'd17, op, 2'b01, 16'h3C5A});
        chk("R3 no MDC edges", 32'(rise_n - base), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R10 watchdog act=running exp=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 reset word", acc_q, 32'd0);
        chk("R5 reset lines", {30'd0, mdc, mdio_oe}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        bad_op(2'b00);
        bad_op(2'b11);
        for (int k = 0; k < 24; k++) begin
            logic [5:0] dv;
            dv = (k % 3 == 0) ? 6'd0 : ((k % 3 == 1) ? 6'd1 : 6'd3);
            run_txn(5'((k * 11 + 1) % 32), 5'((k * 7 + 3) % 32),
                    (k % 2 == 0) ? 2'b01 : 2'b10,
                    16'(16'hA5C3 ^ (k * 16'h1357)), 16'(16'h5A3C + k * 16'h0F21),
                    dv, 1'((k / 2) % 2), 1'b0);
        end
        run_txn(5'd31, 5'd0, 2'b01, 16'hFFFF, 16'h0000, 6'd2, 1'b1, 1'b1);
        run_txn(5'd0, 5'd31, 2'b10, 16'h0000, 16'h8001, 6'd2, 1'b0, 1'b1);
        finish_run();
    end
endmodule